// File: doc/BRIEF.md
# Flash Bad-Block Scan Engine

After a NAND flash is fitted into a system, its factory-marked unusable blocks have to be found before anything else touches the array. This engine walks the blocks one after another. For each block it asks a separate page-read engine for single marker bytes over a small request/response interface, and it decides whether the block is usable. A block counts as unusable when either of its marker bytes has been cleared from the erased value (all ones) or when the read engine reports an error. The result for each block goes into an internal one-bit-per-block map, which the rest of the system queries through a lookup port.

A scan starts with a single-cycle `start` pulse. While the scan runs the engine keeps a count of unusable blocks. It raises a warning when that count goes past the number of bad blocks the part is allowed to have, which is the block total minus the guaranteed minimum of good blocks. It also keeps a sticky flag for any error response. The engine only ever issues reads, so no map it builds can lead to an erase of a marked block. Block 0 is guaranteed usable, so it is never read and always looks up as good.

Top module: `flash_badblock_scan`

## Requirements
- R1: After reset, `busy`, `rd_req_valid`, `scan_done`, `bad_count`, `bad_warn` and `err_seen` are all 0, and every lookup returns 0.
- R2: A scan requests rows in ascending order. For each block b from 1 up to `NUM_BLOCKS-1` it asks for page 0 and then page 1, with row = b × `PAGES_PER_BLOCK` + page and column `MARKER_COL` (default 2048). Block 0 is never requested.
- R3: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays asserted and `rd_req_row` and `rd_req_col` hold their values.
- R4: A block is recorded as bad when the response byte for either of its pages differs from 8'hFF. It is recorded as good when both bytes equal 8'hFF.
- R5: A response with `rsp_err` high marks its block bad, whatever the data, and sets `err_seen`. `err_seen` stays set until the next accepted `start`.
- R6: A lookup of block 0 always returns 0 (good).
- R7: At the end of a scan, `bad_count` equals the number of blocks recorded bad. `bad_warn` is 1 exactly when `bad_count` exceeds `NUM_BLOCKS - MIN_GOOD` (40 by default), so a count equal to that limit leaves it at 0.
- R8: `scan_done` is high for exactly one cycle after the last block's result is recorded. `busy` is low in that same cycle.
- R9: `lu_bad` shows the map entry for `lu_addr` one cycle after the address is presented (1 = bad). From an accepted `start` until that scan's `scan_done`, every lookup returns 0.
- R10: A `start` pulse while `busy` is high has no effect. The running scan carries on in order and produces only one `scan_done`.
- R11: At most one read is outstanding. After a request is accepted, no new request is raised until a response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle pulse that begins a scan when the engine is idle |
| rd_req_valid | output | 1 | Read request to the page-read engine is pending |
| rd_req_ready | input | 1 | Page-read engine accepts the request this cycle |
| rd_req_row | output | 17 | Row (page) address of the request |
| rd_req_col | output | 12 | Column of the requested byte |
| rsp_valid | input | 1 | Response byte is present |
| rsp_data | input | 8 | Marker byte read from the array |
| rsp_err | input | 1 | Read engine could not deliver the byte |
| busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle pulse at the end of a scan |
| bad_count | output | 12 | Number of blocks recorded bad in the current or last scan |
| bad_warn | output | 1 | Bad count exceeds the allowed bad-block limit |
| err_seen | output | 1 | Sticky flag: an error response arrived in this scan |
| lu_addr | input | 11 | Block number to look up |
| lu_bad | output | 1 | Map entry for the looked-up block, one cycle later |

## Verification
The cycle-by-cycle properties hold on every clock: a pending request stays stable until it is taken, no second request goes out while a read is outstanding, requests never target block 0 and always use the marker column, the done pulse lasts one cycle with busy low, the warning stays off below the limit, and the count never goes down during a scan. Whether each block's verdict is right, whether the row order is complete, whether the error flag clears at the next start, what the lookups return, and that a start in mid-scan is ignored can only be shown by the bench scenarios. The bench compares every request against a queue of expected rows and reads back the whole map after each scan.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REQ    = 2'd1,
    ST_WAIT   = 2'd2,
    ST_COMMIT = 2'd3
  } scan_st_e;

endpackage

// File: rtl/fbs_walker.sv
// Block and page position of the scan; forms the row address.
module fbs_walker #(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int ROW_W = BLK_W + PG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             adv_page,
  input  logic             adv_block,
  output logic [BLK_W-1:0] blk,
  output logic             page,
  output logic [ROW_W-1:0] row,
  output logic             last
);

  localparam logic [BLK_W-1:0] FIRST_BLK = BLK_W'(1);
  localparam logic [BLK_W-1:0] LAST_BLK  = BLK_W'(NUM_BLOCKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      blk  <= FIRST_BLK;
      page <= 1'b0;
    end else if (init) begin
      blk  <= FIRST_BLK;
      page <= 1'b0;
    end else if (adv_block) begin
      blk  <= blk + BLK_W'(1);
      page <= 1'b0;
    end else if (adv_page) begin
      page <= 1'b1;
    end
  end

  always_comb begin
    row  = ROW_W'(blk) * ROW_W'(PAGES_PER_BLOCK) + ROW_W'(page);
    last = (blk == LAST_BLK);
  end

endmodule

// File: rtl/fbs_tally.sv
// Counts bad blocks and keeps the registered over-limit warning.
module fbs_tally #(
  parameter int NUM_BLOCKS = 2048,
  parameter int MIN_GOOD   = 2008,
  localparam int CNT_W   = $clog2(NUM_BLOCKS + 1),
  localparam int MAX_BAD = NUM_BLOCKS - MIN_GOOD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             warn
);

  logic [CNT_W-1:0] count_nx;

  always_comb count_nx = count + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
      warn  <= 1'b0;
    end else if (inc) begin
      count <= count_nx;
      warn  <= (count_nx > CNT_W'(MAX_BAD));
    end
  end

endmodule

// File: rtl/fbs_bitmap.sv
// One bit per block, single write port, registered read (block RAM style).
module fbs_bitmap #(
  parameter int NUM_BLOCKS = 2048,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [BLK_W-1:0] waddr,
  input  logic             wdata,
  input  logic             map_valid,
  input  logic [BLK_W-1:0] raddr,
  output logic             rdata
);

  logic mem [NUM_BLOCKS];
  logic rd_q;
  logic gate_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= map_valid && (raddr != '0);
  end

  always_comb rdata = rd_q & gate_q;

endmodule

// File: rtl/flash_badblock_scan.sv
module flash_badblock_scan #(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MIN_GOOD        = 2008,
  parameter int COL_W           = 12,
  parameter int MARKER_COL      = 2048,
  parameter int DATA_W          = 8,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int ROW_W = BLK_W + PG_W,
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ROW_W-1:0]  rd_req_row,
  output logic [COL_W-1:0]  rd_req_col,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_err,
  output logic              busy,
  output logic              scan_done,
  output logic [CNT_W-1:0]  bad_count,
  output logic              bad_warn,
  output logic              err_seen,
  input  logic [BLK_W-1:0]  lu_addr,
  output logic              lu_bad
);
  import fbs_pkg::*;

  scan_st_e         state;
  logic             bad_acc;
  logic             map_valid;
  logic [BLK_W-1:0] blk;
  logic             page;
  logic             last;
  logic             go, adv_page, adv_block, commit, rsp_bad;

  always_comb begin
    go        = (state == ST_IDLE) && start;
    rsp_bad   = rsp_err || (rsp_data != {DATA_W{1'b1}});
    adv_page  = (state == ST_WAIT) && rsp_valid && !page;
    commit    = (state == ST_COMMIT);
    adv_block = commit && !last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bad_acc   <= 1'b0;
      err_seen  <= 1'b0;
      scan_done <= 1'b0;
      map_valid <= 1'b0;
    end else begin
      scan_done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_REQ;
          bad_acc   <= 1'b0;
          err_seen  <= 1'b0;
          map_valid <= 1'b0;
        end
        ST_REQ: if (rd_req_ready) state <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          bad_acc  <= bad_acc | rsp_bad;
          err_seen <= err_seen | rsp_err;
          state    <= page ? ST_COMMIT : ST_REQ;
        end
        ST_COMMIT: begin
          bad_acc <= 1'b0;
          if (last) begin
            state     <= ST_IDLE;
            scan_done <= 1'b1;
            map_valid <= 1'b1;
          end else begin
            state <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  fbs_walker #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
  ) u_walker (
    .clk(clk), .rst(rst), .init(go), .adv_page(adv_page),
    .adv_block(adv_block), .blk(blk), .page(page),
    .row(rd_req_row), .last(last)
  );

  fbs_tally #(
    .NUM_BLOCKS(NUM_BLOCKS), .MIN_GOOD(MIN_GOOD)
  ) u_tally (
    .clk(clk), .rst(rst), .clear(go), .inc(commit && bad_acc),
    .count(bad_count), .warn(bad_warn)
  );

  fbs_bitmap #(
    .NUM_BLOCKS(NUM_BLOCKS)
  ) u_map (
    .clk(clk), .rst(rst), .we(commit), .waddr(blk), .wdata(bad_acc),
    .map_valid(map_valid), .raddr(lu_addr), .rdata(lu_bad)
  );

  always_comb begin
    busy         = (state != ST_IDLE);
    rd_req_valid = (state == ST_REQ);
    rd_req_col   = COL_W'(MARKER_COL);
  end

endmodule

// File: rtl/fbs_scan_checker.sv
module fbs_scan_checker #(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MIN_GOOD        = 2008,
  parameter int COL_W           = 12,
  parameter int MARKER_COL      = 2048,
  localparam int BLK_W   = $clog2(NUM_BLOCKS),
  localparam int PG_W    = $clog2(PAGES_PER_BLOCK),
  localparam int ROW_W   = BLK_W + PG_W,
  localparam int CNT_W   = $clog2(NUM_BLOCKS + 1),
  localparam int MAX_BAD = NUM_BLOCKS - MIN_GOOD
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic [ROW_W-1:0] rd_req_row,
  input logic [COL_W-1:0] rd_req_col,
  input logic             rsp_valid,
  input logic             busy,
  input logic             scan_done,
  input logic [CNT_W-1:0] bad_count,
  input logic             bad_warn
);

  logic pending_q;

  always_ff @(posedge clk) begin
    if (rst)                               pending_q <= 1'b0;
    else if (rd_req_valid && rd_req_ready) pending_q <= 1'b1;
    else if (rsp_valid)                    pending_q <= 1'b0;
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_row));

  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (rst)
    pending_q |-> !rd_req_valid);

  p_req_target_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> (rd_req_row >= ROW_W'(PAGES_PER_BLOCK)) &&
                     (rd_req_col == COL_W'(MARKER_COL)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_req_valid);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> !busy);

  p_warn_below_r7: assert property (@(posedge clk) disable iff (rst)
    bad_count <= CNT_W'(MAX_BAD) |-> !bad_warn);

  p_count_mono_r7: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> bad_count >= $past(bad_count));

endmodule

bind flash_badblock_scan fbs_scan_checker #(
  .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
  .MIN_GOOD(MIN_GOOD), .COL_W(COL_W), .MARKER_COL(MARKER_COL)
) u_fbs_chk (
  .clk(clk), .rst(rst), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rd_req_row(rd_req_row),
  .rd_req_col(rd_req_col), .rsp_valid(rsp_valid), .busy(busy),
  .scan_done(scan_done), .bad_count(bad_count), .bad_warn(bad_warn)
);

// File: tb/test_flash_badblock_scan.sv
module test_flash_badblock_scan;

  localparam int CLK_PERIOD = 10;
  localparam int NB    = 16;
  localparam int PPB   = 64;
  localparam int MING  = 13;          // allowed bad = 3
  localparam int COLW  = 12;
  localparam int MCOL  = 2048;
  localparam int BLK_W = $clog2(NB);
  localparam int ROW_W = BLK_W + $clog2(PPB);
  localparam int CNT_W = $clog2(NB + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rd_req_valid, rd_req_ready;
  logic [ROW_W-1:0] rd_req_row;
  logic [COLW-1:0]  rd_req_col;
  logic rsp_valid, rsp_err;
  logic [7:0] rsp_data;
  logic busy, scan_done, bad_warn, err_seen, lu_bad;
  logic [CNT_W-1:0] bad_count;
  logic [BLK_W-1:0] lu_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_badblock_scan #(
    .NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .MIN_GOOD(MING),
    .COL_W(COLW), .MARKER_COL(MCOL), .DATA_W(8)
  ) i_flash_badblock_scan (
    .clk(clk), .rst(rst), .start(start),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_row(rd_req_row), .rd_req_col(rd_req_col),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .busy(busy), .scan_done(scan_done), .bad_count(bad_count),
    .bad_warn(bad_warn), .err_seen(err_seen),
    .lu_addr(lu_addr), .lu_bad(lu_bad)
  );

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;

  logic [7:0] pg0_val [NB];
  logic [7:0] pg1_val [NB];
  logic       err0 [NB];
  logic       err1 [NB];
  logic       exp_bad [NB];
  logic [ROW_W-1:0] exp_q [$];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // Driver: set the array pattern, predict the map and the request order.
  task automatic plan_scan();
    exp_q.delete();
    for (int b = 0; b < NB; b++)
      exp_bad[b] = (pg0_val[b] != 8'hFF) || (pg1_val[b] != 8'hFF) || err0[b] || err1[b];
    exp_bad[0] = 1'b0;
    for (int b = 1; b < NB; b++) begin
      exp_q.push_back(ROW_W'(b * PPB));
      exp_q.push_back(ROW_W'(b * PPB + 1));
    end
  endtask

  task automatic clear_pattern();
    for (int b = 0; b < NB; b++) begin
      pg0_val[b] = 8'hFF; pg1_val[b] = 8'hFF; err0[b] = 1'b0; err1[b] = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
  endtask

  task automatic lookup(input int b, input int exp, input string req);
    @(negedge clk) lu_addr = BLK_W'(b);
    @(negedge clk) chk(req, int'(lu_bad), exp);
  endtask

  task automatic check_map(input string req);
    for (int b = 0; b < NB; b++) lookup(b, int'(exp_bad[b]), req);
  endtask

  // Read-engine model plus scoreboard monitor.
  initial begin
    int cyc = 0;
    int cnt = 0;
    int blk, pg;
    logic prev_done = 1'b0;
    rd_req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = 8'h00; rsp_err = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = 1'b0; rsp_err = 1'b0; rsp_data = 8'h00;
      if (!rst) begin
        if (scan_done) begin
          done_cnt++;
          chk("R8 busy low at done", int'(busy), 0);
        end
        if (scan_done && prev_done) chk("R8 done width", 1, 0);
        prev_done = scan_done;
        if (cnt > 0) begin
          cnt--;
          if (cnt == 0) begin
            rsp_valid = 1'b1;
            rsp_data  = (pg == 0) ? pg0_val[blk] : pg1_val[blk];
            rsp_err   = (pg == 0) ? err0[blk] : err1[blk];
          end
        end
        rd_req_ready = (cyc % 3 != 1);
        if (rd_req_valid && rd_req_ready) begin
          if (exp_q.size() == 0) chk("R2 unexpected request", int'(rd_req_row), -1);
          else chk("R2 request row", int'(rd_req_row), int'(exp_q.pop_front()));
          chk("R2 request column", int'(rd_req_col), MCOL);
          blk = int'(rd_req_row) / PPB;
          pg  = int'(rd_req_row) % PPB;
          cnt = 2;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8: watchdog, got no completion expected scan_done");
    finish_run();
  end

  initial begin
    clear_pattern();
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 request", int'(rd_req_valid), 0);
    chk("R1 done", int'(scan_done), 0);
    chk("R1 count", int'(bad_count), 0);
    chk("R1 warn", int'(bad_warn), 0);
    chk("R1 err", int'(err_seen), 0);
    lookup(5, 0, "R1 lookup after reset");
    @(negedge clk) rst = 1'b0;

    // Scan A: marker cleared on page 0 of block 3, page 1 of block 5.
    clear_pattern();
    pg0_val[3] = 8'h00; pg1_val[5] = 8'hFE;
    plan_scan();
    pulse_start();
    wait_done(1);
    chk("R2 all rows requested", exp_q.size(), 0);
    chk("R7 count scan A", int'(bad_count), 2);
    chk("R7 warn scan A", int'(bad_warn), 0);
    chk("R5 err scan A", int'(err_seen), 0);
    check_map("R4 map scan A");
    lookup(0, 0, "R6 block 0 good");

    // Scan B: error response, both pages bad, one bit cleared, last block.
    clear_pattern();
    err0[2] = 1'b1; pg0_val[2] = 8'hFF;
    pg0_val[7] = 8'h12; pg1_val[7] = 8'h34;
    pg0_val[9] = 8'h7F;
    pg1_val[NB-1] = 8'hEF;
    plan_scan();
    pulse_start();
    lookup(3, 0, "R9 lookup during scan");
    pulse_start();                         // R10: ignored while busy
    wait_done(2);
    repeat (4) @(negedge clk);
    chk("R10 single done", done_cnt, 2);
    chk("R2 all rows requested B", exp_q.size(), 0);
    chk("R7 count scan B", int'(bad_count), 4);
    chk("R7 warn over limit", int'(bad_warn), 1);
    chk("R5 err sticky", int'(err_seen), 1);
    check_map("R4 R5 map scan B");

    // Scan C: exactly at the limit, no errors.
    clear_pattern();
    pg1_val[1] = 8'h00; pg0_val[8] = 8'hFB; pg1_val[14] = 8'h01;
    plan_scan();
    pulse_start();
    wait_done(3);
    chk("R7 count at limit", int'(bad_count), 3);
    chk("R7 warn at limit", int'(bad_warn), 0);
    chk("R5 err cleared by start", int'(err_seen), 0);
    check_map("R9 map scan C");
    lookup(0, 0, "R6 block 0 after scan C");

    finish_run();
  end

endmodule